// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

This peripheral drives two pulse-width modulated outputs from a single clock. Software programs it through a small word-addressed register port. One shared control register holds a group of fields per channel. Each channel also has its own period/duty register. Each channel divides the input clock by a ratio picked from a fixed table of irregular divide values. It then counts prescaled cycles across a programmable period and holds its output at the active level for a programmable number of those cycles. Per-channel fields select the polarity, single-pulse operation and a bypass that sends the divided reference clock straight to the pin.

Each channel has a four-state machine. `ST_OFF` is stopped. `ST_RUN` is free-running. `ST_ARM` is in single-pulse mode, waiting for a trigger. `ST_FIRE` is emitting one pulse. The transitions are:
- from any state to `ST_OFF` when the channel stops running (enable or clock gate low);
- `ST_OFF` to `ST_RUN`, or to `ST_ARM` when the pulse-mode field is set;
- `ST_RUN` to `ST_ARM` when pulse mode is selected;
- `ST_ARM` to `ST_FIRE` when the pulse field is set;
- `ST_ARM` or `ST_FIRE` back to `ST_RUN` when pulse mode is cleared;
- `ST_FIRE` to `ST_ARM` at the end of the period, when hardware also clears the pulse field.

Period writes land in a shadow copy. The shadow moves into the working copy at the end of the running period, or on the next cycle when the counter is idle. A busy flag is visible while the transfer is pending.

Top module: `pwm2_ctrl`

## Requirements
- R1: Register map (byte offsets on `reg_addr`): 0x0 is the control register and 0x4 + 4*n is channel n's period/duty register. In the period/duty register, bits [23:16] hold the period value P and bits [7:0] hold the duty value D. A read of this register returns the last written P and D with all other bits 0.
- R2: The prescaler code selects the divide ratio of the prescaled tick. Codes 0..4 give 120, 180, 240, 360 and 480. Codes 8..12 give 12000, 24000, 36000, 48000 and 72000. Code 15 gives 1.
- R3: A running channel has a period of P+1 prescaled ticks. Its counter runs 0..P and wraps. The output is active while count < D, so D = 0 gives a constant inactive output and D > P gives a constant active output.
- R4: The active-state field set to 1 makes the active level high. Set to 0, it makes the active level low and the inactive level high. The field resets to 0, so both outputs sit high after reset.
- R5: The control fields of channel n start at bit 15*n: [3:0] prescaler code, +4 enable, +5 active state, +6 clock gate, +7 pulse mode, +8 pulse trigger, +9 bypass. Read-back returns these fields in the same positions.
- R6: A channel runs only when both enable and clock gate are 1. Otherwise its counter holds at zero and its output drives the inactive level.
- R7: A period/duty write sets a pending flag, readable at control bit 28+n. The flag clears, and the new values take effect, at the next counter wrap while running, or one cycle after the write while not counting.
- R8: In pulse mode, setting the pulse trigger produces exactly one period with D active ticks. Hardware then clears the trigger, and the output stays inactive until the trigger is set again.
- R9: With bypass set, a running channel outputs the prescaled reference clock, which toggles on every prescaled tick and starts low, regardless of polarity.
- R10: Reserved codes 5, 6, 7, 13 and 14 produce no prescaled tick, so the counter stays at 0 and the output holds the level for count 0.
- R11: After reset the control register and both period/duty registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| pwm_o | output | 2 | Channel outputs, bit n for channel n |

## Verification
The main duty function is driven from a table of code, period, duty and polarity sets. The bench counts active output cycles over a whole number of periods, so the count depends only on the waveform and not on its phase. The set includes:
- zero duty and a duty beyond the period, which separate the two constant outputs from the compare path;
- an inverted-polarity case, which separates the polarity logic from the duty count;
- several divide codes, which tell a wrong ratio apart from a wrong period.

Directed tests then check the field stride on channel 1, each gate combination, the pending flag with a deferred and an immediate transfer, single pulses, bypass toggling and a reserved code.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

    localparam int CODE_W   = 4;
    localparam int PS_DIV_W = 17;
    localparam int FIELD_W  = 10;

    localparam int F_EN    = 4;
    localparam int F_ACT   = 5;
    localparam int F_GATE  = 6;
    localparam int F_MODE  = 7;
    localparam int F_PULSE = 8;
    localparam int F_BYP   = 9;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_RUN,
        ST_ARM,
        ST_FIRE
    } ch_state_e;

    // Divide ratio per prescaler code; 0 marks a reserved code (no tick).
    function automatic logic [PS_DIV_W-1:0] div_ratio(input logic [CODE_W-1:0] code);
        logic [PS_DIV_W-1:0] r;
        case (code)
            4'd0:    r = PS_DIV_W'(120);
            4'd1:    r = PS_DIV_W'(180);
            4'd2:    r = PS_DIV_W'(240);
            4'd3:    r = PS_DIV_W'(360);
            4'd4:    r = PS_DIV_W'(480);
            4'd8:    r = PS_DIV_W'(12000);
            4'd9:    r = PS_DIV_W'(24000);
            4'd10:   r = PS_DIV_W'(36000);
            4'd11:   r = PS_DIV_W'(48000);
            4'd12:   r = PS_DIV_W'(72000);
            4'd15:   r = PS_DIV_W'(1);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler
    import pwm2_pkg::*;
#(
    parameter int DIV_W = PS_DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o,
    output logic              ref_o
);

    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] pcnt_q;
    logic             ref_q;

    assign ratio  = DIV_W'(div_ratio(code_i));
    assign tick_o = run_i && (ratio != '0) && (pcnt_q >= ratio - 1'b1);
    assign ref_o  = ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            ref_q  <= 1'b0;
        end else if (!run_i) begin
            pcnt_q <= '0;
            ref_q  <= 1'b0;
        end else if (tick_o) begin
            pcnt_q <= '0;
            ref_q  <= ~ref_q;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R9
    ref_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (ref_q != $past(ref_q)));

endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
    import pwm2_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              en_i,
    input  logic              act_i,
    input  logic              gate_i,
    input  logic              mode_i,
    input  logic              pulse_i,
    input  logic              byp_i,
    input  logic              wr_i,
    input  logic [CNT_W-1:0]  prd_i,
    input  logic [CNT_W-1:0]  duty_i,
    output logic [CNT_W-1:0]  sh_prd_o,
    output logic [CNT_W-1:0]  sh_duty_o,
    output logic              pending_o,
    output logic              pulse_done_o,
    output logic              out_o
);

    ch_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] sh_prd_q, sh_duty_q, prd_q, duty_q;
    logic             pend_q;
    logic             run, counting, tick, ref_clk, wrap, take;

    assign run      = en_i && gate_i;
    assign counting = (st_q == ST_RUN) || (st_q == ST_FIRE);
    assign wrap     = counting && tick && (cnt_q == prd_q);
    assign take     = pend_q && (!counting || wrap);

    pwm2_prescaler u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (counting),
        .code_i (code_i),
        .tick_o (tick),
        .ref_o  (ref_clk)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:  if (run) st_d = mode_i ? ST_ARM : ST_RUN;
            ST_RUN:  if (!run) st_d = ST_OFF;
                     else if (mode_i) st_d = ST_ARM;
            ST_ARM:  if (!run) st_d = ST_OFF;
                     else if (!mode_i) st_d = ST_RUN;
                     else if (pulse_i) st_d = ST_FIRE;
            ST_FIRE: if (!run) st_d = ST_OFF;
                     else if (!mode_i) st_d = ST_RUN;
                     else if (wrap) st_d = ST_ARM;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // Period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (st_q != st_d)     cnt_q <= '0;
        else if (counting && tick) cnt_q <= (cnt_q == prd_q) ? '0 : cnt_q + 1'b1;
    end

    // Shadow and working period/duty
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_prd_q  <= '0;
            sh_duty_q <= '0;
            prd_q     <= '0;
            duty_q    <= '0;
            pend_q    <= 1'b0;
        end else begin
            if (take) begin
                prd_q  <= sh_prd_q;
                duty_q <= sh_duty_q;
            end
            if (wr_i) begin
                sh_prd_q  <= prd_i;
                sh_duty_q <= duty_i;
                pend_q    <= 1'b1;
            end else if (take) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign sh_prd_o     = sh_prd_q;
    assign sh_duty_o    = sh_duty_q;
    assign pending_o    = pend_q;
    assign pulse_done_o = (st_q == ST_FIRE) && run && mode_i && wrap;

    // Output process
    always_comb begin
        out_o = ~act_i;
        unique case (st_q)
            ST_OFF, ST_ARM: out_o = ~act_i;
            ST_RUN, ST_FIRE: begin
                if (byp_i)               out_o = ref_clk;
                else if (cnt_q < duty_q) out_o = act_i;
                else                     out_o = ~act_i;
            end
        endcase
    end

    // R6
    gated_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= prd_q);

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !counting && !wr_i) |=> !pend_q);

    // R8
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_done_o |=> (st_q == ST_ARM));

endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
    import pwm2_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int CNT_W     = 8,
    parameter int STRIDE    = 15,
    parameter int RDY_BASE  = 28,
    parameter int PRD_LSB   = 16,
    parameter bit HAS_READY = 1'b1,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    logic [FIELD_W-1:0] fields   [NUM_CH];
    logic [CNT_W-1:0]   sh_prd   [NUM_CH];
    logic [CNT_W-1:0]   sh_duty  [NUM_CH];
    logic [NUM_CH-1:0]  pending;
    logic [NUM_CH-1:0]  pulse_done;
    logic               ctrl_hit;
    logic [DATA_W-1:0]  ctrl_word;
    logic               unused_wdata;

    assign ctrl_hit     = reg_wr && (reg_addr == CTRL_ADDR);
    assign unused_wdata = ^reg_wdata;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] PRD_ADDR = ADDR_W'(4 + 4 * ch);
        logic [FIELD_W-1:0] fld_q;
        logic               prd_hit;

        assign prd_hit = reg_wr && (reg_addr == PRD_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               fld_q <= '0;
            else if (ctrl_hit)        fld_q <= reg_wdata[ch*STRIDE +: FIELD_W];
            else if (pulse_done[ch])  fld_q[F_PULSE] <= 1'b0;
        end

        assign fields[ch] = fld_q;

        pwm2_channel #(.CNT_W(CNT_W)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .code_i       (fld_q[CODE_W-1:0]),
            .en_i         (fld_q[F_EN]),
            .act_i        (fld_q[F_ACT]),
            .gate_i       (fld_q[F_GATE]),
            .mode_i       (fld_q[F_MODE]),
            .pulse_i      (fld_q[F_PULSE]),
            .byp_i        (fld_q[F_BYP]),
            .wr_i         (prd_hit),
            .prd_i        (reg_wdata[PRD_LSB +: CNT_W]),
            .duty_i       (reg_wdata[CNT_W-1:0]),
            .sh_prd_o     (sh_prd[ch]),
            .sh_duty_o    (sh_duty[ch]),
            .pending_o    (pending[ch]),
            .pulse_done_o (pulse_done[ch]),
            .out_o        (pwm_o[ch])
        );

        // R8
        pulse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_done[ch] && !ctrl_hit) |=> !fld_q[F_PULSE]);
    end

    always_comb begin
        ctrl_word = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            ctrl_word[ch*STRIDE +: FIELD_W] = fields[ch];
            if (HAS_READY) ctrl_word[RDY_BASE + ch] = pending[ch];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_ADDR) reg_rdata = ctrl_word;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (reg_addr == ADDR_W'(4 + 4 * ch)) begin
                reg_rdata[PRD_LSB +: CNT_W] = sh_prd[ch];
                reg_rdata[CNT_W-1:0]        = sh_duty[ch];
            end
        end
    end

endmodule

// File: tb/pwm2_ctrl_tb.sv
module pwm2_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pwm_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwm2_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_o     (pwm_o)
    );

    typedef struct packed {
        logic [3:0] code;
        logic [7:0] prd;
        logic [7:0] duty;
        logic       act;
        logic [3:0] nper;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd15, 8'd3,   8'd2,   1'b1, 4'd5},
        '{4'd15, 8'd9,   8'd0,   1'b1, 4'd2},
        '{4'd15, 8'd4,   8'd9,   1'b1, 4'd3},
        '{4'd15, 8'd7,   8'd3,   1'b0, 4'd3},
        '{4'd0,  8'd3,   8'd1,   1'b1, 4'd2},
        '{4'd2,  8'd1,   8'd1,   1'b1, 4'd2},
        '{4'd15, 8'd255, 8'd128, 1'b1, 4'd1},
        '{4'd4,  8'd0,   8'd1,   1'b1, 4'd3},
        '{4'd8,  8'd1,   8'd1,   1'b1, 4'd1},
        '{4'd3,  8'd2,   8'd2,   1'b0, 4'd1}
    };

    function automatic int ratio_of(input logic [3:0] c);
        case (c)
            4'd0: return 120;    4'd1: return 180;    4'd2: return 240;
            4'd3: return 360;    4'd4: return 480;    4'd8: return 12000;
            4'd9: return 24000;  4'd10: return 36000; 4'd11: return 48000;
            4'd12: return 72000; 4'd15: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] cw(input int ch, input logic [3:0] code,
        input logic en, input logic act, input logic gate,
        input logic mode, input logic pulse, input logic byp);
        logic [31:0] f;
        f = {22'd0, byp, pulse, mode, gate, act, en, code};
        return f << (15 * ch);
    endfunction

    task automatic check(input string tag, input longint act_v, input longint exp_v);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hi += int'(pwm_o[ch]);
        end
    endtask

    task automatic prd_word(input logic [7:0] p, input logic [7:0] d, output logic [31:0] w);
        w = {8'd0, p, 8'd0, d};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, w;
        int hi, tog, exp_hi, win, per_act;
        logic prev;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 / R4: reset state
        bus_read(4'h0, rd); check("R11 ctrl reset", rd, 0);
        bus_read(4'h4, rd); check("R11 ch0 period reset", rd, 0);
        bus_read(4'h8, rd); check("R11 ch1 period reset", rd, 0);
        check("R4 idle outputs high after reset", pwm_o, 3);

        // R1: register map and period read-back
        bus_write(4'h8, 32'hFFAB_FFCD);
        bus_read(4'h8, rd); check("R1 ch1 period readback", rd, 32'h00AB_00CD);
        bus_read(4'h4, rd); check("R1 ch0 untouched", rd, 0);

        // R5: field stride read-back
        w = cw(0, 4'd3, 0, 1, 0, 1, 0, 1) | cw(1, 4'd9, 1, 0, 0, 0, 1, 0);
        bus_write(4'h0, w);
        bus_read(4'h0, rd); check("R5 ctrl fields readback", rd, w);
        bus_write(4'h0, 32'h0);

        // R2 R3 R4: vector table on channel 0
        for (int v = 0; v < NV; v++) begin
            bus_write(4'h0, cw(0, VECS[v].code, 0, VECS[v].act, 0, 0, 0, 0));
            prd_word(VECS[v].prd, VECS[v].duty, w);
            bus_write(4'h4, w);
            repeat (2) @(negedge clk);
            bus_write(4'h0, cw(0, VECS[v].code, 1, VECS[v].act, 1, 0, 0, 0));
            win = (int'(VECS[v].prd) + 1) * ratio_of(VECS[v].code) * int'(VECS[v].nper);
            if (VECS[v].duty == 0) per_act = 0;
            else if (VECS[v].duty > VECS[v].prd) per_act = int'(VECS[v].prd) + 1;
            else per_act = int'(VECS[v].duty);
            per_act = per_act * ratio_of(VECS[v].code) * int'(VECS[v].nper);
            exp_hi = VECS[v].act ? per_act : win - per_act;
            count_high(0, win, hi);
            check($sformatf("R2 R3 R4 vector %0d high count", v), hi, exp_hi);
        end
        bus_write(4'h0, 32'h0);

        // R5: channel 1 control at stride 15, channel 0 idle
        prd_word(8'd4, 8'd2, w);
        bus_write(4'h8, w);
        repeat (2) @(negedge clk);
        bus_write(4'h0, cw(1, 4'd15, 1, 1, 1, 0, 0, 0));
        count_high(1, 25, hi); check("R5 ch1 high count", hi, 10);
        check("R5 ch0 stays idle high", pwm_o[0], 1);
        bus_write(4'h0, 32'h0);

        // R6: gating combinations
        prd_word(8'd3, 8'd2, w);
        bus_write(4'h4, w);
        bus_write(4'h0, cw(0, 4'd15, 1, 1, 0, 0, 0, 0));
        count_high(0, 20, hi); check("R6 gate low gives inactive low", hi, 0);
        bus_write(4'h0, cw(0, 4'd15, 0, 0, 1, 0, 0, 0));
        count_high(0, 20, hi); check("R6 enable low gives inactive high", hi, 20);

        // R7: pending flag, deferred transfer while running
        bus_write(4'h0, 32'h0);
        prd_word(8'd200, 8'd100, w);
        bus_write(4'h4, w);
        repeat (2) @(negedge clk);
        bus_write(4'h0, cw(0, 4'd15, 1, 1, 1, 0, 0, 0));
        repeat (5) @(negedge clk);
        prd_word(8'd9, 8'd5, w);
        bus_write(4'h4, w);
        bus_read(4'h0, rd); check("R7 busy flag set while running", rd[28], 1);
        check("R7 ch1 flag clear", rd[29], 0);
        repeat (210) @(negedge clk);
        bus_read(4'h0, rd); check("R7 busy flag cleared after wrap", rd[28], 0);
        count_high(0, 100, hi); check("R7 new period in effect", hi, 50);

        // R7: immediate transfer while stopped
        bus_write(4'h0, 32'h0);
        prd_word(8'd3, 8'd1, w);
        bus_write(4'h4, w);
        bus_read(4'h0, rd); check("R7 busy right after write", rd[28], 1);
        @(negedge clk);
        bus_read(4'h0, rd); check("R7 stopped transfer next cycle", rd[28], 0);

        // R8: single pulses
        prd_word(8'd5, 8'd3, w);
        bus_write(4'h4, w);
        repeat (2) @(negedge clk);
        bus_write(4'h0, cw(0, 4'd15, 1, 1, 1, 1, 0, 0));
        count_high(0, 10, hi); check("R8 armed output inactive", hi, 0);
        bus_write(4'h0, cw(0, 4'd15, 1, 1, 1, 1, 1, 0));
        count_high(0, 30, hi); check("R8 one pulse of duty length", hi, 3);
        bus_read(4'h0, rd); check("R8 trigger cleared", rd, cw(0, 4'd15, 1, 1, 1, 1, 0, 0));
        bus_write(4'h0, cw(0, 4'd15, 1, 1, 1, 1, 1, 0));
        count_high(0, 30, hi); check("R8 second pulse", hi, 3);

        // R9: bypass follows the prescaled reference
        bus_write(4'h0, 32'h0);
        bus_write(4'h0, cw(0, 4'd15, 1, 0, 1, 0, 0, 1));
        @(negedge clk);
        prev = pwm_o[0];
        check("R9 reference starts low", prev, 0);
        tog = 0; hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_o[0] != prev) tog++;
            prev = pwm_o[0];
            hi += int'(pwm_o[0]);
        end
        check("R9 toggles every tick", tog, 20);
        check("R9 half high", hi, 10);

        // R10: reserved code freezes the counter at 0
        bus_write(4'h0, 32'h0);
        prd_word(8'd3, 8'd1, w);
        bus_write(4'h4, w);
        repeat (2) @(negedge clk);
        bus_write(4'h0, cw(0, 4'd5, 1, 1, 1, 0, 0, 0));
        count_high(0, 40, hi); check("R10 reserved code holds count-0 level", hi, 40);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule